// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing register set of a small serial port. A host reaches it over an APB-style bus with zero wait states. The port exposes three live registers: a data port, a status word and a control word. The serial framing and the bit-rate logic sit elsewhere. On this side, received bytes arrive on a valid/ready byte stream and are held in a linear buffer until the host reads them. Bytes the host writes leave on a byte-stream output.

A read of the data port hands back the oldest held byte and consumes it. Once the last held byte has been read, the buffer restarts from its first slot. Control bits gate reception and transmission. Two further bits choose whether a stored byte, a sent byte, or both raise the single interrupt line. Only the low address byte is decoded. The divider register offset and every unused offset read as zero and ignore writes.

Top module: `uart_regfront`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000_0006 (bit 1 and bit 2 set, all others clear), rxReady is high and irqPulse is low.
- R2: The data port answers at both offset 0x00 and offset 0x03 with identical read-to-consume and transmit behaviour.
- R3: An input byte is stored only while control bit 0 (receive enable) is set. While it is clear the byte is accepted and dropped, so status bit 0 stays 0 and a data read returns 0.
- R4: Status bit 0 (data ready) is set by storing a byte. It clears when the last held byte is read or when the data port is read while the buffer is empty.
- R5: Data reads return held bytes in arrival order. A read of an empty buffer returns 0. After the buffer drains, the next byte is stored at the first slot.
- R6: rxReady is low exactly while DEPTH bytes are held, so no input byte is ever overwritten or lost.
- R7: A bus write to the data port drives txValid high during its access cycle, with txData equal to bits 7:0 of the write data, only when control bit 1 (transmit enable) is set. Otherwise nothing is emitted.
- R8: irqPulse is high for one cycle after each cycle in which a byte was stored with control bit 2 set or a byte was emitted with control bit 3 set. When both happen in the same cycle, only one pulse results.
- R9: The control word at offset 0x08 takes all 32 written bits and reads them back. Writes to status (0x04), to the divider (0x0C) and to unused offsets change nothing. The divider and unused offsets read as 0.
- R10: Status bit 8 is set while at least DEPTH/2 bytes are held, and status bit 10 is set while DEPTH bytes are held.
- R11: When an input byte is stored in the same cycle as the read that drains the buffer, that byte is kept as the only held byte and data ready stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | Bus select |
| pEnable | input | 1 | Bus access phase |
| pWrite | input | 1 | Bus write (1) or read (0) |
| pAddr | input | ADDR_W | Byte offset, low byte decoded |
| pWdata | input | DATA_W | Bus write data |
| pRdata | output | DATA_W | Bus read data, valid in access phase |
| pReady | output | 1 | Always high (no wait states) |
| rxValid | input | 1 | Incoming byte present |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | Buffer has free space |
| txValid | output | 1 | Outgoing byte strobe |
| txData | output | 8 | Outgoing byte |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a stored input byte and an emitted byte, which compete for the single interrupt line. The bench raises rxValid during the access cycle of a data-port write with both interrupt enables set. It then expects exactly one high cycle of irqPulse, one emitted byte and one stored byte. The second pair is an input byte and the read that drains the buffer. The bench presents a byte during that read and judges the result by reading it back and by checking that data ready remains set.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int OFS_DATA      = 'h00;
  localparam int OFS_DATA_BYTE = 'h03;
  localparam int OFS_STAT      = 'h04;
  localparam int OFS_CTRL      = 'h08;
  localparam int OFS_DIV       = 'h0C;

  localparam int CTL_RX_EN  = 0;
  localparam int CTL_TX_EN  = 1;
  localparam int CTL_RX_IRQ = 2;
  localparam int CTL_TX_IRQ = 3;

  localparam int ST_DREADY = 0;
  localparam int ST_TSHIFT = 1;
  localparam int ST_TFIFO  = 2;
  localparam int ST_RHALF  = 8;
  localparam int ST_RFULL  = 10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL
  } regSel_e;

  typedef struct packed {
    logic pop;
    logic push;
    logic ctrlWr;
    logic txFire;
  } strobes_t;

endpackage

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  input  logic              rxValid,
  input  logic              rxReady,
  output strobes_t          strb,
  output regSel_e           regSel,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irqPulse
);

  logic [7:0] offs;
  logic       access;
  logic       irqQ;

  assign offs   = pAddr[7:0];
  assign access = pSel & pEnable;

  always_comb begin
    unique case (offs)
      8'(OFS_DATA), 8'(OFS_DATA_BYTE): regSel = SEL_DATA;
      8'(OFS_STAT):                    regSel = SEL_STAT;
      8'(OFS_CTRL):                    regSel = SEL_CTRL;
      default:                         regSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.pop    = access & ~pWrite & (regSel == SEL_DATA);
    strb.push   = rxValid & rxReady & ctrlQ[CTL_RX_EN];
    strb.ctrlWr = access & pWrite & (regSel == SEL_CTRL);
    strb.txFire = access & pWrite & (regSel == SEL_DATA) & ctrlQ[CTL_TX_EN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (strb.ctrlWr) ctrlQ <= pWdata;
      irqQ <= (strb.push & ctrlQ[CTL_RX_IRQ]) | (strb.txFire & ctrlQ[CTL_TX_IRQ]);
    end
  end

  assign txValid  = strb.txFire;
  assign txData   = pWdata[7:0];
  assign irqPulse = irqQ;

  // R8: a pulse always follows an event of the previous cycle
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strb.push | strb.txFire));

  // R9: control word changes only on a control write
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWr |=> $stable(ctrlQ));

  // R7: an emitted byte always comes from a bus write access
  a_r7_tx_from_write: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (pSel && pEnable && pWrite));

endmodule

// File: rtl/uart_rf_dpath.sv
module uart_rf_dpath
  import uart_rf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regSel_e           regSel,
  input  logic [DATA_W-1:0] ctrlQ,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic [DATA_W-1:0] pRdata
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] fillQ;
  logic [CNT_W-1:0] rdIdxQ;
  logic             dReadyQ;
  logic             drain;
  logic [IDX_W-1:0] wrAddr;
  logic [7:0]       headByte;
  logic [DATA_W-1:0] statWord;

  assign rxReady  = fillQ < CNT_W'(DEPTH);
  assign drain    = strb.pop && ((fillQ == '0) || (rdIdxQ + CNT_W'(1) >= fillQ));
  assign wrAddr   = drain ? '0 : fillQ[IDX_W-1:0];
  assign headByte = (fillQ != '0) ? mem[rdIdxQ[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrAddr] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillQ   <= '0;
      rdIdxQ  <= '0;
      dReadyQ <= 1'b0;
    end else if (drain) begin
      rdIdxQ  <= '0;
      fillQ   <= strb.push ? CNT_W'(1) : '0;
      dReadyQ <= strb.push;
    end else begin
      if (strb.pop)  rdIdxQ <= rdIdxQ + CNT_W'(1);
      if (strb.push) begin
        fillQ   <= fillQ + CNT_W'(1);
        dReadyQ <= 1'b1;
      end
    end
  end

  always_comb begin
    statWord            = '0;
    statWord[ST_DREADY] = dReadyQ;
    statWord[ST_TSHIFT] = 1'b1;
    statWord[ST_TFIFO]  = 1'b1;
    statWord[ST_RHALF]  = fillQ >= CNT_W'(DEPTH / 2);
    statWord[ST_RFULL]  = fillQ == CNT_W'(DEPTH);
  end

  always_comb begin
    unique case (regSel)
      SEL_DATA: pRdata = DATA_W'(headByte);
      SEL_STAT: pRdata = statWord;
      SEL_CTRL: pRdata = ctrlQ;
      default:  pRdata = '0;
    endcase
  end

  // R6: held count never exceeds the buffer depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillQ <= CNT_W'(DEPTH));

  // R4: data ready agrees with a non-empty buffer
  a_r4_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rstN)
    dReadyQ == (fillQ != '0));

  // R5: read index stays inside the filled part, and is zero when empty
  a_r5_idx_inside: assert property (@(posedge clk) disable iff (!rstN)
    (fillQ == '0) ? (rdIdxQ == '0) : (rdIdxQ < fillQ));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              pReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irqPulse
);

  strobes_t          strb;
  regSel_e           regSel;
  logic [DATA_W-1:0] ctrlQ;

  assign pReady = 1'b1;

  uart_rf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pSel     (pSel),
    .pEnable  (pEnable),
    .pWrite   (pWrite),
    .pAddr    (pAddr),
    .pWdata   (pWdata),
    .rxValid  (rxValid),
    .rxReady  (rxReady),
    .strb     (strb),
    .regSel   (regSel),
    .ctrlQ    (ctrlQ),
    .txValid  (txValid),
    .txData   (txData),
    .irqPulse (irqPulse)
  );

  uart_rf_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regSel  (regSel),
    .ctrlQ   (ctrlQ),
    .rxData  (rxData),
    .rxReady (rxReady),
    .pRdata  (pRdata)
  );

endmodule

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady, txValid, irqPulse;
  logic [7:0]  txData;

  int chkCnt = 0;
  int errCnt = 0;
  int irqCnt = 0;
  int txCnt  = 0;
  logic [7:0] lastTx = '0;

  always #2.5 clk = ~clk;

  uart_regfront #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .irqPulse(irqPulse)
  );

  always begin
    @(negedge clk);
    #1;
    if (irqPulse) irqCnt++;
    if (txValid) begin
      txCnt++;
      lastTx = txData;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apbAccess(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, input logic alsoRx, input logic [7:0] rxb);
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = wr; pAddr = a; pWdata = wd;
    @(negedge clk);
    pEnable = 1'b1;
    if (alsoRx) begin rxValid = 1'b1; rxData = rxb; end
    #1 rd = pRdata;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0; rxValid = 1'b0;
  endtask

  task automatic apbWr(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] dummy;
    apbAccess(1'b1, a, wd, dummy, 1'b0, 8'h00);
  endtask

  task automatic apbRd(input logic [7:0] a, output logic [31:0] rd);
    apbAccess(1'b0, a, 32'h0, rd, 1'b0, 8'h00);
  endtask

  task automatic pushByte(input logic [7:0] b, output logic acc);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    #1 acc = rxReady;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 5);
    errCnt++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        acc;
    int          c0, t0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(rxReady == 1'b1, "R1 rxReady", 32'(rxReady), 32'h1);
    chk(irqPulse == 1'b0, "R1 irq", 32'(irqPulse), 32'h0);
    apbRd(8'h04, rd); chk(rd == 32'h6, "R1 status", rd, 32'h6);
    apbRd(8'h08, rd); chk(rd == 32'h0, "R1 control", rd, 32'h0);

    // R3: receive disabled, byte dropped
    pushByte(8'h55, acc);
    chk(acc == 1'b1, "R3 accepted while disabled", 32'(acc), 32'h1);
    apbRd(8'h04, rd); chk(rd[0] == 1'b0, "R3 no data ready", rd, 32'h6);
    apbRd(8'h00, rd); chk(rd == 32'h0, "R3 data zero", rd, 32'h0);

    // R9: register access rules
    apbWr(8'h08, 32'hA5A5_C3F0); apbRd(8'h08, rd);
    chk(rd == 32'hA5A5_C3F0, "R9 control full word", rd, 32'hA5A5_C3F0);
    apbWr(8'h08, 32'h1);
    apbWr(8'h04, 32'hFFFF_FFFF); apbRd(8'h04, rd); chk(rd == 32'h6, "R9 status ignores write", rd, 32'h6);
    apbWr(8'h0C, 32'h1234); apbRd(8'h0C, rd); chk(rd == 32'h0, "R9 divider zero", rd, 32'h0);
    apbWr(8'h10, 32'h77); apbRd(8'h10, rd); chk(rd == 32'h0, "R9 unused zero", rd, 32'h0);
    apbRd(8'h08, rd); chk(rd == 32'h1, "R9 control unchanged", rd, 32'h1);

    // R4 R5 R6 R10 R2: fill level sweep
    c0 = irqCnt;
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        pushByte(8'((n * 7 + i * 13) & 255), acc);
        chk(acc == 1'b1, "R6 accept with space", 32'(acc), 32'h1);
      end
      apbRd(8'h04, rd);
      chk(rd[0] == 1'b1, "R4 data ready set", rd, 32'h1);
      chk(rd[8] == (n >= DEPTH / 2), "R10 half flag", 32'(rd[8]), 32'(n >= DEPTH / 2));
      chk(rd[10] == (n == DEPTH), "R10 full flag", 32'(rd[10]), 32'(n == DEPTH));
      if (n == DEPTH) begin
        pushByte(8'hEE, acc);
        chk(acc == 1'b0, "R6 ready low when full", 32'(acc), 32'h0);
      end
      for (int i = 0; i < n; i++) begin
        apbRd(((i % 2) == 1) ? 8'h03 : 8'h00, rd);
        chk(rd == 32'((n * 7 + i * 13) & 255), "R5 R2 read order", rd, 32'((n * 7 + i * 13) & 255));
      end
      apbRd(8'h04, rd); chk(rd[0] == 1'b0, "R4 cleared on drain", rd, 32'h6);
      apbRd(8'h00, rd); chk(rd == 32'h0, "R5 empty read zero", rd, 32'h0);
      apbRd(8'h04, rd); chk(rd == 32'h6, "R4 empty read status", rd, 32'h6);
    end
    settle();
    chk(irqCnt == c0, "R8 no irq when disabled", 32'(irqCnt), 32'(c0));

    // R8: receive interrupt
    apbWr(8'h08, 32'h5);
    c0 = irqCnt;
    pushByte(8'h3C, acc);
    settle();
    chk(irqCnt == c0 + 1, "R8 rx pulse one cycle", 32'(irqCnt), 32'(c0 + 1));
    apbRd(8'h00, rd); chk(rd == 32'h3C, "R5 single byte", rd, 32'h3C);

    // R7: transmit gating
    apbWr(8'h08, 32'h1);
    t0 = txCnt;
    apbWr(8'h00, 32'h1A7);
    chk(txCnt == t0, "R7 no tx when disabled", 32'(txCnt), 32'(t0));
    apbWr(8'h08, 32'h3);
    c0 = irqCnt;
    for (int v = 0; v < 256; v++) begin
      t0 = txCnt;
      apbWr(((v % 2) == 1) ? 8'h03 : 8'h00, 32'(v) | 32'hABCD_0000);
      chk(txCnt == t0 + 1 && lastTx == 8'(v), "R7 R2 tx byte", 32'(lastTx), 32'(v));
    end
    settle();
    chk(irqCnt == c0, "R8 no tx irq when disabled", 32'(irqCnt), 32'(c0));

    // R8: transmit interrupt
    apbWr(8'h08, 32'hB);
    c0 = irqCnt;
    apbWr(8'h00, 32'h61);
    settle();
    chk(irqCnt == c0 + 1, "R8 tx pulse", 32'(irqCnt), 32'(c0 + 1));

    // R8: simultaneous events merge into one pulse
    apbWr(8'h08, 32'hF);
    c0 = irqCnt; t0 = txCnt;
    apbAccess(1'b1, 8'h00, 32'h99, rd, 1'b1, 8'h4D);
    settle();
    chk(irqCnt == c0 + 1, "R8 merged pulse", 32'(irqCnt), 32'(c0 + 1));
    chk(txCnt == t0 + 1, "R8 merged tx", 32'(txCnt), 32'(t0 + 1));
    apbRd(8'h00, rd); chk(rd == 32'h4D, "R8 merged rx stored", rd, 32'h4D);

    // R11: store during draining read
    apbWr(8'h08, 32'h1);
    pushByte(8'h11, acc);
    apbAccess(1'b0, 8'h00, 32'h0, rd, 1'b1, 8'h22);
    chk(rd == 32'h11, "R11 drained byte", rd, 32'h11);
    apbRd(8'h04, rd); chk(rd[0] == 1'b1, "R11 ready kept", rd, 32'h7);
    apbRd(8'h00, rd); chk(rd == 32'h22, "R11 new byte kept", rd, 32'h22);
    apbRd(8'h04, rd); chk(rd == 32'h6, "R11 drained after", rd, 32'h6);

    // R11: store during read of empty buffer
    apbAccess(1'b0, 8'h03, 32'h0, rd, 1'b1, 8'h5A);
    chk(rd == 32'h0, "R11 empty read zero", rd, 32'h0);
    apbRd(8'h00, rd); chk(rd == 32'h5A, "R11 stored at empty read", rd, 32'h5A);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule